// File: doc/BRIEF.md
# Serial-Commanded Pin Grid Column Controller

This block turns short serial commands from a host processor into drive signals for a 16 by 16 field of solenoid pins. The drive hardware works on one column at a time. The host sends fixed 19-bit packets over a SPI link, where this block is the slave in mode 0. Each packet carries a running command number, a pin index within the active column, a height level and an opcode. The block checks each packet's length, parity, the busy condition and the command number, in that order. It then either executes the packet or rejects it. On every following transfer it shifts a status word back to the host.

Pin height is set by time. A set-pins command enables one row line and raises the drive signal for (level+1)×`TICKS_PER_LEVEL` clock cycles. A longer pulse pushes the pin further. A reset-column command enables all sixteen row lines together with the column-reset strobe for the same kind of timed interval. An increment command gives a single-cycle column-advance strobe. A no-op only advances the command number.

A controller state machine has three states:
- IDLE: waiting for work.
- DRIVE: a timed pulse is in progress.
- STEP: the one-cycle column-advance strobe.

Its transitions are:
- IDLE→DRIVE when a set-pins or reset-column command is accepted.
- IDLE→STEP when an increment command is accepted.
- IDLE→IDLE when a no-op is accepted.
- DRIVE→IDLE when the pulse timer reaches its last cycle.
- STEP→IDLE unconditionally.

Top module: `pin_column_ctrl`

## Requirements
- R1: After reset, `row_en`, `col_inc`, `col_rst`, `drive`, `busy` and `inst_num` are all zero, and the first transfer returns an all-zero status word on `spi_miso`.
- R2: A packet is exactly 19 bits, sent MSB first and framed by `spi_cs_n` low. The bit fields are: [18:11] command number, [10:7] pin index, [6:4] level, [3:2] opcode, [1] reserved, [0] parity. A frame of any other length has no effect and gets status 3'b100 with command number 0.
- R3: Parity is even over all 19 bits. A packet with odd parity has no effect and gets status 3'b001.
- R4: After reset the expected command number is 0. Each accepted packet sets the expected number to its own number plus one. A well-formed packet with any other number has no effect and gets status 3'b011.
- R5: Opcode 2'b00 (set pins) drives `row_en` to `1 << pin` and holds `drive` high for exactly (level+1)×`TICKS_PER_LEVEL` cycles.
- R6: Opcode 2'b01 (increment column) raises `col_inc` for exactly one cycle, with `drive` low and `row_en` zero.
- R7: Opcode 2'b10 (reset column) holds `row_en` at all ones with `col_rst` and `drive` high for exactly (level+1)×`TICKS_PER_LEVEL` cycles.
- R8: Opcode 2'b11 (no-op) is accepted and advances the command number, but raises no output.
- R9: `busy` is high in exactly the cycles in which an accepted command executes. A well-formed, correctly numbered packet that completes while busy has no effect and gets status 3'b010.
- R10: During the transfer after a packet, `spi_miso` shifts out {status[2:0], command number[7:0], 8'b0} MSB first. Status 3'b000 means the packet was accepted. `inst_num` shows the number of the last accepted packet.
- R11: When several checks fail at once, the status reported is the first failing check in the order length, parity, busy, sequence.
- R12: The reserved bit has no effect on how a packet is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host (mode 0) |
| spi_cs_n | input | 1 | Active-low frame select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial status to host |
| row_en | output | 16 | Row lines enabled in the active column |
| col_inc | output | 1 | One-cycle column-advance strobe |
| col_rst | output | 1 | Column-reset drive strobe |
| drive | output | 1 | Solenoid drive pulse |
| busy | output | 1 | A command is executing |
| inst_num | output | 8 | Number of the last accepted command |

## Verification
The hardest case to reach from the ports is a packet that arrives while a pulse is still running. A full 19-bit frame takes over three hundred clock cycles, which is longer than short pulses. The bench therefore builds the block with a large `TICKS_PER_LEVEL` and starts a level-7 pulse. It then sends the next frame straight away, once with a correct number and once with bad parity. This exercises both the busy rejection and its rank below the parity check. Every status, including that of a truncated frame, is read back on the transfer that follows.

// File: rtl/pin_column_pkg.sv
package pin_column_pkg;

    localparam int PKT_BITS = 19;
    localparam int SEQ_W    = 8;
    localparam int PIN_W    = 4;
    localparam int LVL_W    = 3;
    localparam int OP_W     = 2;
    localparam int STAT_W   = 3;
    localparam int ROWS     = 1 << PIN_W;

    typedef enum logic [OP_W-1:0] {
        OP_SET   = 2'b00,
        OP_STEP  = 2'b01,
        OP_CLEAR = 2'b10,
        OP_NOP   = 2'b11
    } op_e;

    typedef enum logic [STAT_W-1:0] {
        ST_OK     = 3'b000,
        ST_PARITY = 3'b001,
        ST_BUSY   = 3'b010,
        ST_SEQ    = 3'b011,
        ST_FRAME  = 3'b100
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_DRIVE = 2'b01,
        S_STEP  = 2'b10
    } ctrl_state_e;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [PIN_W-1:0] pin;
        logic [LVL_W-1:0] level;
        op_e              op;
        logic             rsvd;
        logic             par;
    } packet_t;

endpackage

// File: rtl/pcl_spi_link.sv
module pcl_spi_link #(
    parameter int BITS = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            mosi,
    output logic            miso,
    input  logic [BITS-1:0] resp,
    output logic            frame_done,
    output logic            frame_full,
    output logic [BITS-1:0] frame_data
);

    localparam int CW      = $clog2(BITS + 2);
    localparam int CNT_MAX = BITS + 1;

    logic [2:0]      sclk_q;
    logic [2:0]      cs_q;
    logic [1:0]      mosi_q;
    logic [CW-1:0]   bit_cnt;
    logic [BITS-1:0] rx_sh;
    logic [BITS-1:0] tx_sh;

    logic sclk_rise, sclk_fall, cs_active, cs_start, cs_end;

    // input synchronisers, data aligned with the clock edge detect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign sclk_rise = sclk_q[1] & ~sclk_q[2];
    assign sclk_fall = ~sclk_q[1] & sclk_q[2];
    assign cs_active = ~cs_q[1];
    assign cs_start  = ~cs_q[1] & cs_q[2];
    assign cs_end    = cs_q[1] & ~cs_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= cs_end;
            if (cs_start) begin
                bit_cnt <= '0;
                tx_sh   <= resp;
            end else if (cs_active) begin
                if (sclk_rise) begin
                    rx_sh <= {rx_sh[BITS-2:0], mosi_q[1]};
                    if (bit_cnt != CW'(CNT_MAX)) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (sclk_fall) begin
                    tx_sh <= {tx_sh[BITS-2:0], 1'b0};
                end
            end
        end
    end

    assign miso       = tx_sh[BITS-1];
    assign frame_full = (bit_cnt == CW'(BITS));
    assign frame_data = rx_sh;

endmodule

// File: rtl/pcl_packet_check.sv
module pcl_packet_check
    import pin_column_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  logic                frame_full,
    input  logic [PKT_BITS-1:0] frame_data,
    input  logic                busy_in,
    output logic                accept,
    output packet_t             cmd,
    output status_e             resp_code,
    output logic [SEQ_W-1:0]    resp_inst,
    output logic [SEQ_W-1:0]    last_inst
);

    packet_t          pkt;
    logic [SEQ_W-1:0] exp_seq;
    logic             parity_ok;
    logic             seq_ok;
    status_e          verdict;

    assign pkt       = packet_t'(frame_data);
    assign parity_ok = ~(^frame_data);
    assign seq_ok    = (pkt.seq == exp_seq);

    // fixed check order: length, parity, busy, sequence
    always_comb begin
        if (!frame_full) begin
            verdict = ST_FRAME;
        end else if (!parity_ok) begin
            verdict = ST_PARITY;
        end else if (busy_in) begin
            verdict = ST_BUSY;
        end else if (!seq_ok) begin
            verdict = ST_SEQ;
        end else begin
            verdict = ST_OK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept    <= 1'b0;
            cmd       <= '0;
            resp_code <= ST_OK;
            resp_inst <= '0;
            last_inst <= '0;
            exp_seq   <= '0;
        end else begin
            accept <= 1'b0;
            if (frame_done) begin
                resp_code <= verdict;
                resp_inst <= frame_full ? pkt.seq : '0;
                if (verdict == ST_OK) begin
                    accept    <= 1'b1;
                    cmd       <= pkt;
                    exp_seq   <= pkt.seq + 1'b1;
                    last_inst <= pkt.seq;
                end
            end
        end
    end

endmodule

// File: rtl/pcl_pulse_timer.sv
module pcl_pulse_timer #(
    parameter int TICKS = 50000,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] level,
    output logic          last
);

    localparam int MAXLEN = TICKS * (1 << LW);
    localparam int CW     = $clog2(MAXLEN + 1);

    logic [CW-1:0] remain;
    logic [CW-1:0] len;

    // (level + 1) * TICKS cycles of drive
    assign len = CW'(level) * CW'(TICKS) + CW'(TICKS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= len;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == CW'(1));

endmodule

// File: rtl/pin_column_ctrl.sv
module pin_column_ctrl
    import pin_column_pkg::*;
#(
    parameter int TICKS_PER_LEVEL = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic [ROWS-1:0]  row_en,
    output logic             col_inc,
    output logic             col_rst,
    output logic             drive,
    output logic             busy,
    output logic [SEQ_W-1:0] inst_num
);

    localparam int PAD_W = PKT_BITS - STAT_W - SEQ_W;

    logic                frame_done;
    logic                frame_full;
    logic [PKT_BITS-1:0] frame_data;
    logic [PKT_BITS-1:0] resp_word;
    logic                accept;
    packet_t             cmd;
    status_e             resp_code;
    logic [SEQ_W-1:0]    resp_inst;
    logic                timer_load;
    logic                timer_last;
    ctrl_state_e         state, state_nx;

    assign resp_word = {resp_code, resp_inst, {PAD_W{1'b0}}};

    pcl_spi_link #(.BITS(PKT_BITS)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .miso       (spi_miso),
        .resp       (resp_word),
        .frame_done (frame_done),
        .frame_full (frame_full),
        .frame_data (frame_data)
    );

    pcl_packet_check u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_full (frame_full),
        .frame_data (frame_data),
        .busy_in    (busy | accept),
        .accept     (accept),
        .cmd        (cmd),
        .resp_code  (resp_code),
        .resp_inst  (resp_inst),
        .last_inst  (inst_num)
    );

    assign timer_load = accept && (state == S_IDLE) &&
                        ((cmd.op == OP_SET) || (cmd.op == OP_CLEAR));

    pcl_pulse_timer #(.TICKS(TICKS_PER_LEVEL), .LW(LVL_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .level (cmd.level),
        .last  (timer_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    unique case (cmd.op)
                        OP_SET, OP_CLEAR: state_nx = S_DRIVE;
                        OP_STEP:          state_nx = S_STEP;
                        OP_NOP:           state_nx = S_IDLE;
                    endcase
                end
            end
            S_DRIVE: if (timer_last) state_nx = S_IDLE;
            S_STEP:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        row_en  = '0;
        col_inc = 1'b0;
        col_rst = 1'b0;
        drive   = 1'b0;
        busy    = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_DRIVE: begin
                drive = 1'b1;
                busy  = 1'b1;
                if (cmd.op == OP_CLEAR) begin
                    row_en  = '1;
                    col_rst = 1'b1;
                end else begin
                    row_en = ROWS'(1) << cmd.pin;
                end
            end
            S_STEP: begin
                col_inc = 1'b1;
                busy    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pin_column_ctrl_sva.sv
module pin_column_ctrl_sva #(
    parameter int ROWS = 16,
    parameter int SW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            drive,
    input logic [ROWS-1:0] row_en,
    input logic            col_inc,
    input logic            col_rst,
    input logic [SW-1:0]   inst_num
);

    a_r1_rows_quiet_without_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (row_en == '0));

    a_r5_row_single_or_full: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> ($onehot(row_en) || (&row_en)));

    a_r6_inc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        col_inc |=> !col_inc);

    a_r6_inc_without_drive: assert property (@(posedge clk) disable iff (!rst_n)
        col_inc |-> (!drive && !col_rst));

    a_r7_clear_drives_all: assert property (@(posedge clk) disable iff (!rst_n)
        col_rst |-> (drive && (&row_en)));

    a_r9_drive_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (drive || col_inc) |-> busy);

    a_r4_number_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inst_num) |-> (inst_num == $past(inst_num) + 1'b1));

endmodule

bind pin_column_ctrl pin_column_ctrl_sva #(.ROWS(16), .SW(8)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .drive    (drive),
    .row_en   (row_en),
    .col_inc  (col_inc),
    .col_rst  (col_rst),
    .inst_num (inst_num)
);

// File: tb/tb_pin_column_ctrl.sv
module tb_pin_column_ctrl;

    localparam int N    = 64;
    localparam int HALF = 8;

    typedef struct packed {
        logic       rsvd;
        logic [7:0] seq;
        logic [3:0] pin;
        logic [2:0] lvl;
        logic [1:0] op;
        logic       badpar;
        logic [2:0] code;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0, 4'd3,  3'd0, 2'd0, 1'b0, 3'd0},   // R5 set, level 0
        '{1'b0, 8'd1, 4'd15, 3'd2, 2'd0, 1'b0, 3'd0},   // R5 set, level 2
        '{1'b0, 8'd2, 4'd0,  3'd0, 2'd1, 1'b0, 3'd0},   // R6 increment
        '{1'b0, 8'd3, 4'd0,  3'd1, 2'd2, 1'b0, 3'd0},   // R7 column reset
        '{1'b0, 8'd4, 4'd9,  3'd5, 2'd3, 1'b0, 3'd0},   // R8 no-op
        '{1'b0, 8'd5, 4'd2,  3'd0, 2'd0, 1'b1, 3'd1},   // R3 bad parity
        '{1'b0, 8'd7, 4'd2,  3'd0, 2'd0, 1'b0, 3'd3},   // R4 wrong number
        '{1'b1, 8'd5, 4'd0,  3'd0, 2'd0, 1'b0, 3'd0},   // R12 reserved set
        '{1'b0, 8'd6, 4'd0,  3'd0, 2'd1, 1'b0, 3'd0}    // R6 again
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] row_en;
    logic        col_inc, col_rst, drive, busy;
    logic [7:0]  inst_num;

    int checks = 0;
    int fails  = 0;

    logic        mon_clr = 1'b1;
    int          n_drive, n_inc, n_rst, n_busy;
    logic [15:0] row_or;

    always #10 clk = ~clk;

    pin_column_ctrl #(.TICKS_PER_LEVEL(N)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .row_en   (row_en),
        .col_inc  (col_inc),
        .col_rst  (col_rst),
        .drive    (drive),
        .busy     (busy),
        .inst_num (inst_num)
    );

    always @(negedge clk) begin
        if (mon_clr) begin
            n_drive = 0; n_inc = 0; n_rst = 0; n_busy = 0; row_or = '0;
        end else begin
            if (drive)   n_drive++;
            if (col_inc) n_inc++;
            if (col_rst) n_rst++;
            if (busy)    n_busy++;
            row_or |= row_en;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    function automatic logic [18:0] mk(input logic rsvd, input logic [7:0] seq,
                                       input logic [3:0] pin, input logic [2:0] lvl,
                                       input logic [1:0] op, input logic badpar);
        logic [18:0] p;
        p = {seq, pin, lvl, op, rsvd, 1'b0};
        p[0] = (^p) ^ badpar;
        return p;
    endfunction

    task automatic xfer(input logic [18:0] tx, input int nbits, output logic [18:0] rx);
        rx = '0;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = tx[18-i];
            repeat (HALF) @(negedge clk);
            rx[18-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic settle();
        repeat (600) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [18:0] rx;
        logic [2:0]  prev_code;
        logic [7:0]  prev_inst;
        logic [7:0]  last_acc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        mon_clr = 1'b0;

        // R1 reset state
        chk("R1 row_en", 32'(row_en), 32'h0);
        chk("R1 strobes", {28'h0, col_inc, col_rst, drive, busy}, 32'h0);
        chk("R1 inst_num", 32'(inst_num), 32'h0);

        prev_code = 3'd0;
        prev_inst = 8'd0;
        last_acc  = 8'd0;

        for (int v = 0; v < NV; v++) begin
            vec_t e;
            int   exp_drive, exp_inc, exp_rst;
            logic [15:0] exp_row;
            bit   ok;
            e = VECS[v];
            ok = (e.code == 3'd0);
            exp_drive = (ok && (e.op == 2'd0 || e.op == 2'd2)) ? (int'(e.lvl) + 1) * N : 0;
            exp_inc   = (ok && e.op == 2'd1) ? 1 : 0;
            exp_rst   = (ok && e.op == 2'd2) ? exp_drive : 0;
            exp_row   = !ok ? 16'h0 : (e.op == 2'd0) ? (16'h1 << e.pin) :
                        (e.op == 2'd2) ? 16'hFFFF : 16'h0;
            clear_mon();
            xfer(mk(e.rsvd, e.seq, e.pin, e.lvl, e.op, e.badpar), 19, rx);
            // R10 response for the previous packet
            chk($sformatf("R10 status v%0d", v), 32'(rx), 32'({prev_code, prev_inst, 8'h0}));
            settle();
            if (ok) last_acc = e.seq;
            chk($sformatf("R5/R7 drive cycles v%0d", v), 32'(n_drive), 32'(exp_drive));
            chk($sformatf("R6 inc cycles v%0d", v), 32'(n_inc), 32'(exp_inc));
            chk($sformatf("R7 rst cycles v%0d", v), 32'(n_rst), 32'(exp_rst));
            chk($sformatf("R9 busy cycles v%0d", v), 32'(n_busy), 32'(exp_drive + exp_inc));
            chk($sformatf("R5 R8 R12 row v%0d", v), 32'(row_or), 32'(exp_row));
            chk($sformatf("R4 inst_num v%0d", v), 32'(inst_num), 32'(last_acc));
            prev_code = e.code;
            prev_inst = e.seq;
        end

        // R11: bad parity arriving while busy reports parity
        clear_mon();
        xfer(mk(1'b0, 8'd7, 4'd2, 3'd7, 2'd0, 1'b0), 19, rx);
        chk("R10 status before long pulse", 32'(rx), 32'({3'd0, 8'd6, 8'h0}));
        xfer(mk(1'b0, 8'd8, 4'd6, 3'd0, 2'd0, 1'b1), 19, rx);
        chk("R10 status of long pulse", 32'(rx), 32'({3'd0, 8'd7, 8'h0}));
        settle();
        chk("R11 drive only first", 32'(n_drive), 32'(8 * N));
        chk("R11 row only first", 32'(row_or), 32'h0004);

        // R9: correct packet while busy is rejected
        clear_mon();
        xfer(mk(1'b0, 8'd8, 4'd1, 3'd7, 2'd0, 1'b0), 19, rx);
        chk("R11 parity beats busy", 32'(rx), 32'({3'd1, 8'd8, 8'h0}));
        xfer(mk(1'b0, 8'd9, 4'd5, 3'd0, 2'd0, 1'b0), 19, rx);
        chk("R10 status second long", 32'(rx), 32'({3'd0, 8'd8, 8'h0}));
        settle();
        chk("R9 busy drop drive", 32'(n_drive), 32'(8 * N));
        chk("R9 busy drop row", 32'(row_or), 32'h0002);
        chk("R9 inst_num", 32'(inst_num), 32'd8);

        // R8 no-op reusing rejected number
        clear_mon();
        xfer(mk(1'b0, 8'd9, 4'd0, 3'd0, 2'd3, 1'b0), 19, rx);
        chk("R9 busy status", 32'(rx), 32'({3'd2, 8'd9, 8'h0}));
        settle();
        chk("R8 no outputs", 32'(n_busy + n_drive + n_inc + n_rst), 32'd0);
        chk("R8 inst_num", 32'(inst_num), 32'd9);

        // R2 short frame
        clear_mon();
        xfer(mk(1'b0, 8'd10, 4'd4, 3'd0, 2'd1, 1'b0), 7, rx);
        chk("R2 short frame reads top", 32'(rx[18:12]), 32'h0);
        settle();
        chk("R2 short frame no effect", 32'(n_busy + n_drive + n_inc), 32'd0);
        chk("R2 short frame inst", 32'(inst_num), 32'd9);
        xfer(mk(1'b0, 8'd10, 4'd0, 3'd0, 2'd3, 1'b1), 19, rx);
        chk("R2 frame status", 32'(rx), 32'({3'd4, 8'd0, 8'h0}));
        settle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule